// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

A purely combinational arithmetic/logic unit for the execute stage of a small 8-bit RISC core. It produces an 8-bit result from operand A, operand B (a register or an immediate), an incoming carry and an incoming zero flag. It also produces six status flags and a mask that marks which of those flags the selected operation updates. A separate 16-bit path adds or subtracts a small unsigned immediate to or from a register pair.

The core's status register stores only the flags whose mask bit is set, and keeps the others. Flags whose mask bit is clear are driven to 0. There is no stream traffic and no storage, so every pin is a plain level: back-pressure does not apply. A new opcode and new operands may be applied in any cycle, and the outputs follow in the same cycle. For compare operations the difference still appears on `res_o`, and the core simply does not write it back.

Opcode codes, 5 bits on `op_i`: 0 ADD, 1 ADDC, 2 SUB, 3 SUBC, 4 CMP, 5 CMPC, 6 AND, 7 OR, 8 XOR, 9 NOT (ones' complement), 10 NEG, 11 INC, 12 DEC, 13 SHR, 14 SAR, 15 RCR, 16 SHL, 17 RCL, 18 NSWAP, 19 WADD, 20 WSUB. Codes 21 to 31 are unused.

Top module: `alu8_core`

## Requirements
- R1: Flag vector bit order on `flags_o` and `flag_we_o` is bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S, bit5 H; a flag whose mask bit is 0 reads 0. ADD (0) and ADDC (1, adds carry_i) give the 8-bit sum, C = carry out of bit 7, H = carry out of bit 3, V = signed overflow, Z = result is zero, N = bit 7, mask 0x3F.
- R2: SUB (2), SUBC (3, also subtracts carry_i), CMP (4) and CMPC (5, also subtracts carry_i) give A minus B; C = borrow out of bit 7, H = borrow into bit 4, V = signed overflow, N = bit 7, mask 0x3F.
- R3: For SUBC and CMPC, Z is 1 only when the difference is zero and zero_i is 1; for SUB and CMP, Z is simply difference == 0.
- R4: AND (6), OR (7) and XOR (8) give the bitwise result with V = 0 and mask 0x1E (Z, N, V, S).
- R5: NOT (9) gives 0xFF minus A with C = 1 and V = 0, mask 0x1F.
- R6: NEG (10) gives 0x00 minus A with C = (A != 0), V = (A == 0x80), H = borrow into bit 4, mask 0x3F.
- R7: INC (11) and DEC (12) give A+1 and A-1 modulo 256 with V = (A == 0x7F) for INC and V = (A == 0x80) for DEC; the mask is 0x1E, so carry is never updated.
- R8: SHR (13) shifts in 0, SAR (14) keeps bit 7, and RCR (15) moves carry_i into bit 7; all three move bit 0 into C, mask 0x1F.
- R9: SHL (16) shifts in 0 and RCL (17) moves carry_i into bit 0; both move bit 7 into C, mask 0x1F.
- R10: For opcodes 13 to 17, V equals N xor the new C.
- R11: NSWAP (18) exchanges the two nibbles of A and has mask 0.
- R12: Whenever the S mask bit is set, S equals N xor V.
- R13: WADD (19) and WSUB (20) give word_i plus or minus the zero-extended wimm_i on `wres_o`; C is carry or borrow out of bit 15, V is signed overflow, N is bit 15, Z is result == 0, mask 0x1F, and `res_o` equals A. For every other opcode `wres_o` equals word_i.
- R14: Unused opcodes (21 to 31) give `res_o` = A and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Operand A (destination register value) |
| b_i | input | 8 | Operand B (register or immediate) |
| carry_i | input | 1 | Carry flag from the status register |
| zero_i | input | 1 | Zero flag from the status register |
| word_i | input | 16 | Register pair for the word path |
| wimm_i | input | 6 | Unsigned immediate for the word path |
| res_o | output | 8 | Byte result |
| wres_o | output | 16 | Word result |
| flags_o | output | 6 | New flag values, masked |
| flag_we_o | output | 6 | Per-flag update mask |

## Verification
The bound checker watches properties that are local to a single operation, on every input change. These are the carry-preserving mask of increment and decrement, the untouched flags of nibble swap, V cleared by the logic operations, C set by ones' complement, V = N xor C on the shift group, the kept sign bit of SAR, and the sticky-zero rule of the carry-subtract forms. Arithmetic correctness of the sums, borrows, half-carries and overflows, and of the word path, can only be shown by the bench. It sweeps every operand pair for every two-operand opcode, every operand for every unary opcode, and many word values against all immediates, and it compares the results with reference values computed from integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
    OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_SHR  = 5'd13, OP_SAR  = 5'd14, OP_RCR  = 5'd15,
    OP_SHL  = 5'd16, OP_RCL  = 5'd17, OP_NSWP = 5'd18, OP_WADD = 5'd19,
    OP_WSUB = 5'd20
  } alu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_W = 6;

  localparam logic [FLG_W-1:0] MASK_ARITH = 6'h3F;
  localparam logic [FLG_W-1:0] MASK_ZNVS  = 6'h1E;
  localparam logic [FLG_W-1:0] MASK_CZNVS = 6'h1F;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int NIB = W / 2;

  logic [NIB:0] lo;
  logic [W:0]   full;

  always_comb begin
    if (sub_i) begin
      lo   = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    end else begin
      lo   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
    sum_o = full[W-1:0];
    c_o   = full[W];
    h_o   = lo[NIB];
    if (sub_i)
      v_o = (a_i[W-1] ^ b_i[W-1]) & (full[W-1] ^ a_i[W-1]);
    else
      v_o = ~(a_i[W-1] ^ b_i[W-1]) & (full[W-1] ^ a_i[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int NIB = W / 2;

  always_comb begin
    res_o = a_i;
    c_o   = 1'b0;
    case (alu_op_e'(op_i))
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SHR:  begin res_o = {1'b0, a_i[W-1:1]};      c_o = a_i[0];   end
      OP_SAR:  begin res_o = {a_i[W-1], a_i[W-1:1]};  c_o = a_i[0];   end
      OP_RCR:  begin res_o = {carry_i, a_i[W-1:1]};   c_o = a_i[0];   end
      OP_SHL:  begin res_o = {a_i[W-2:0], 1'b0};      c_o = a_i[W-1]; end
      OP_RCL:  begin res_o = {a_i[W-2:0], carry_i};   c_o = a_i[W-1]; end
      OP_NSWP: res_o = {a_i[NIB-1:0], a_i[W-1:NIB]};
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_word.sv
module alu8_word #(
  parameter int WW    = 16,
  parameter int IMM_W = 6
) (
  input  logic [WW-1:0]    word_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sub_i,
  output logic [WW-1:0]    res_o,
  output logic             c_o,
  output logic             v_o
);
  logic [WW:0] ext;
  logic [WW:0] full;

  always_comb begin
    ext   = {{(WW + 1 - IMM_W){1'b0}}, imm_i};
    full  = sub_i ? ({1'b0, word_i} - ext) : ({1'b0, word_i} + ext);
    res_o = full[WW-1:0];
    c_o   = full[WW];
    if (sub_i) v_o = word_i[WW-1] & ~full[WW-1];
    else       v_o = ~word_i[WW-1] & full[WW-1];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             carry_i,
  input  logic             zero_i,
  input  logic [2*W-1:0]   word_i,
  input  logic [IMM_W-1:0] wimm_i,
  output logic [W-1:0]     res_o,
  output logic [2*W-1:0]   wres_o,
  output logic [FLG_W-1:0] flags_o,
  output logic [FLG_W-1:0] flag_we_o
);
  localparam int WW = 2 * W;

  logic [W-1:0]  as_a, as_b, as_sum;
  logic          as_cin, as_sub, as_c, as_h, as_v;
  logic [W-1:0]  bit_res;
  logic          bit_c;
  logic [WW-1:0] w_res;
  logic          w_c, w_v;

  always_comb begin
    as_a   = a_i;
    as_b   = b_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (alu_op_e'(op_i))
      OP_ADDC:         as_cin = carry_i;
      OP_SUB, OP_CMP:  as_sub = 1'b1;
      OP_SUBC, OP_CMPC: begin as_sub = 1'b1; as_cin = carry_i; end
      OP_NEG:  begin as_a = '0; as_b = a_i; as_sub = 1'b1; end
      OP_INC:  as_b = W'(1);
      OP_DEC:  begin as_b = W'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .res_o(bit_res), .c_o(bit_c)
  );

  alu8_word #(.WW(WW), .IMM_W(IMM_W)) u_word (
    .word_i(word_i), .imm_i(wimm_i), .sub_i(op_i == OP_WSUB),
    .res_o(w_res), .c_o(w_c), .v_o(w_v)
  );

  logic [FLG_W-1:0] raw, mask;
  logic [W-1:0]     res;
  logic [WW-1:0]    wres;
  logic             use_word, sticky_z;

  always_comb begin
    res      = a_i;
    wres     = word_i;
    raw      = '0;
    mask     = '0;
    use_word = 1'b0;
    sticky_z = 1'b0;
    case (alu_op_e'(op_i))
      OP_ADD, OP_ADDC, OP_SUB, OP_CMP, OP_NEG: begin
        res = as_sum; raw[FLG_C] = as_c; raw[FLG_H] = as_h; raw[FLG_V] = as_v;
        mask = MASK_ARITH;
      end
      OP_SUBC, OP_CMPC: begin
        res = as_sum; raw[FLG_C] = as_c; raw[FLG_H] = as_h; raw[FLG_V] = as_v;
        mask = MASK_ARITH; sticky_z = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res = as_sum; raw[FLG_V] = as_v; mask = MASK_ZNVS;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = bit_res; mask = MASK_ZNVS;
      end
      OP_NOT: begin
        res = bit_res; raw[FLG_C] = 1'b1; mask = MASK_CZNVS;
      end
      OP_SHR, OP_SAR, OP_RCR, OP_SHL, OP_RCL: begin
        res = bit_res; raw[FLG_C] = bit_c; raw[FLG_V] = bit_res[W-1] ^ bit_c;
        mask = MASK_CZNVS;
      end
      OP_NSWP: res = bit_res;
      OP_WADD, OP_WSUB: begin
        wres = w_res; raw[FLG_C] = w_c; raw[FLG_V] = w_v;
        mask = MASK_CZNVS; use_word = 1'b1;
      end
      default: ;
    endcase
    if (use_word) begin
      raw[FLG_Z] = (wres == '0);
      raw[FLG_N] = wres[WW-1];
    end else begin
      raw[FLG_Z] = (res == '0) & (zero_i | ~sticky_z);
      raw[FLG_N] = res[W-1];
    end
    raw[FLG_S] = raw[FLG_N] ^ raw[FLG_V];
  end

  assign res_o     = res;
  assign wres_o    = wres;
  assign flag_we_o = mask;
  assign flags_o   = raw & mask;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input logic [4:0]       op_i,
  input logic [W-1:0]     a_i,
  input logic             zero_i,
  input logic [W-1:0]     res_o,
  input logic [FLG_W-1:0] flags_o,
  input logic [FLG_W-1:0] flag_we_o
);
  localparam int NIB = W / 2;

  always_comb begin
    if (flag_we_o[FLG_S])
      assert_sign_xor_R12: assert (flags_o[FLG_S] == (flags_o[FLG_N] ^ flags_o[FLG_V]))
        else $error("S differs from N xor V");
    if (op_i == OP_INC || op_i == OP_DEC)
      assert_keep_carry_R7: assert (!flag_we_o[FLG_C])
        else $error("inc/dec updates carry");
    if (op_i == OP_NSWP)
      assert_swap_quiet_R11: assert (flag_we_o == '0 && res_o == {a_i[NIB-1:0], a_i[W-1:NIB]})
        else $error("nibble swap wrong");
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
      assert_logic_vclr_R4: assert (!flags_o[FLG_V] && flag_we_o == MASK_ZNVS)
        else $error("logic op flags wrong");
    if (op_i == OP_NOT)
      assert_not_cset_R5: assert (flags_o[FLG_C] && !flags_o[FLG_V])
        else $error("ones complement flags wrong");
    if (op_i == OP_SHR || op_i == OP_SAR || op_i == OP_RCR || op_i == OP_SHL || op_i == OP_RCL)
      assert_shift_v_R10: assert (flags_o[FLG_V] == (flags_o[FLG_N] ^ flags_o[FLG_C]))
        else $error("shift V rule broken");
    if (op_i == OP_SAR)
      assert_sar_sign_R8: assert (res_o[W-1] == a_i[W-1])
        else $error("arith shift lost sign");
    if (op_i == OP_SUBC || op_i == OP_CMPC)
      assert_sticky_zero_R3: assert (flags_o[FLG_Z] == ((res_o == '0) && zero_i))
        else $error("sticky zero rule broken");
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W), .IMM_W(IMM_W)) chk_i (
  .op_i(op_i), .a_i(a_i), .zero_i(zero_i), .res_o(res_o),
  .flags_o(flags_o), .flag_we_o(flag_we_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [4:0]  op;
  logic [7:0]  a, b;
  logic        cin, zin;
  logic [15:0] word;
  logic [5:0]  wimm;
  logic [7:0]  res;
  logic [15:0] wres;
  logic [5:0]  flags, we;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  alu8_core dut_i (
    .op_i(op), .a_i(a), .b_i(b), .carry_i(cin), .zero_i(zin),
    .word_i(word), .wimm_i(wimm), .res_o(res), .wres_o(wres),
    .flags_o(flags), .flag_we_o(we)
  );

  function automatic int sx8(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string req_of(int o);
    case (o)
      0, 1:             return "R1";
      2, 4:             return "R2";
      3, 5:             return "R3";
      6, 7, 8:          return "R4";
      9:                return "R5";
      10:               return "R6";
      11, 12:           return "R7";
      13, 14, 15:       return "R8";
      16, 17:           return "R9";
      18:               return "R11";
      19, 20:           return "R13";
      default:          return "R14";
    endcase
  endfunction

  task automatic ref_calc(input int o, input int av, input int bv, input int c,
                          input int z, input int wv, input int iv,
                          output int er, output int ef, output int em, output int ewr);
    int r, s, d, sv, fc, fz, fn, fv, fh, wr;
    bit wordop;
    r = av; ewr = wv; em = 0; fc = 0; fv = 0; fh = 0; wordop = 0; wr = wv;
    case (o)
      0, 1: begin
        s  = av + bv + ((o == 1) ? c : 0);
        r  = s & 255; fc = (s > 255);
        fh = ((av & 15) + (bv & 15) + ((o == 1) ? c : 0)) > 15;
        sv = sx8(av) + sx8(bv) + ((o == 1) ? c : 0);
        fv = (sv > 127 || sv < -128); em = 'h3F;
      end
      2, 3, 4, 5: begin
        d  = av - bv - ((o == 3 || o == 5) ? c : 0);
        r  = d & 255; fc = (d < 0);
        fh = ((av & 15) - (bv & 15) - ((o == 3 || o == 5) ? c : 0)) < 0;
        sv = sx8(av) - sx8(bv) - ((o == 3 || o == 5) ? c : 0);
        fv = (sv > 127 || sv < -128); em = 'h3F;
      end
      6: begin r = av & bv; em = 'h1E; end
      7: begin r = av | bv; em = 'h1E; end
      8: begin r = av ^ bv; em = 'h1E; end
      9: begin r = 255 - av; fc = 1; em = 'h1F; end
      10: begin r = (256 - av) & 255; fc = (av != 0); fh = ((av & 15) != 0);
                fv = (av == 128); em = 'h3F; end
      11: begin r = (av + 1) & 255; fv = (av == 127); em = 'h1E; end
      12: begin r = (av + 255) & 255; fv = (av == 128); em = 'h1E; end
      13: begin r = av >> 1; fc = av & 1; em = 'h1F; end
      14: begin r = (av >> 1) | (av & 128); fc = av & 1; em = 'h1F; end
      15: begin r = (av >> 1) | (c << 7); fc = av & 1; em = 'h1F; end
      16: begin r = (av << 1) & 255; fc = av >> 7; em = 'h1F; end
      17: begin r = ((av << 1) & 255) | c; fc = av >> 7; em = 'h1F; end
      18: begin r = ((av & 15) << 4) | (av >> 4); em = 0; end
      19: begin s = wv + iv; wr = s & 65535; fc = (s > 65535);
                fv = (wv < 32768 && wr >= 32768); em = 'h1F; wordop = 1; end
      20: begin d = wv - iv; wr = d & 65535; fc = (d < 0);
                fv = (wv >= 32768 && wr < 32768); em = 'h1F; wordop = 1; end
      default: begin r = av; em = 0; end
    endcase
    if (wordop) begin
      ewr = wr; fz = (wr == 0); fn = wr >> 15;
    end else begin
      fz = (r == 0) && ((o == 3 || o == 5) ? (z == 1) : 1'b1);
      fn = r >> 7;
    end
    if (o >= 13 && o <= 17) fv = fn ^ fc;
    er = r;
    ef = (fc | (fz << 1) | (fn << 2) | (fv << 3) | ((fn ^ fv) << 4) | (fh << 5)) & em;
  endtask

  task automatic run(input int o, input int av, input int bv, input int c,
                     input int z, input int wv, input int iv);
    int er, ef, em, ewr;
    string rq, fq;
    op = 5'(o); a = 8'(av); b = 8'(bv); cin = c[0]; zin = z[0];
    word = 16'(wv); wimm = 6'(iv);
    #1;
    ref_calc(o, av, bv, c, z, wv, iv, er, ef, em, ewr);
    rq = req_of(o);
    fq = (o >= 13 && o <= 17) ? "R10" : rq;
    checks += 4;
    if (int'(res) != er) begin
      errors++;
      $display("FAIL %s res op=%0d a=%02h b=%02h c=%0d: actual %02h expected %02h", rq, o, av, bv, c, res, er);
    end
    if (int'(flags & 6'h2F) != (ef & 'h2F)) begin
      errors++;
      $display("FAIL %s flags op=%0d a=%02h b=%02h c=%0d z=%0d w=%04h i=%0d: actual %02h expected %02h",
               fq, o, av, bv, c, z, wv, iv, flags, ef);
    end
    if (int'(flags[4]) != ((ef >> 4) & 1)) begin
      errors++;
      $display("FAIL R12 S flag op=%0d a=%02h: actual %0d expected %0d", o, av, flags[4], (ef >> 4) & 1);
    end
    if (int'(we) != em || int'(wres) != ewr) begin
      errors++;
      $display("FAIL %s mask/word op=%0d: actual mask %02h wres %04h expected mask %02h wres %04h",
               rq, o, we, wres, em, ewr);
    end
  endtask

  initial begin
    op = 5'd31; a = 8'h5A; b = 8'h00; cin = 0; zin = 0; word = 16'h1234; wimm = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state after reset with an unused opcode (R14)
    run(31, 'h5A, 0, 0, 0, 'h1234, 0);
    // R1 R2 R4: full operand sweeps, carry pattern ignored where not used
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        run(0, x, y, (x ^ y) & 1, (x >> 1) & 1, 0, 0);
        run(2, x, y, (x ^ y) & 1, (x >> 1) & 1, 0, 0);
        run(4, x, y, (x ^ y) & 1, (x >> 1) & 1, 0, 0);
        run(6, x, y, (x ^ y) & 1, 0, 0, 0);
        run(7, x, y, (x ^ y) & 1, 0, 0, 0);
        run(8, x, y, (x ^ y) & 1, 0, 0, 0);
      end
    // R1 R2 R3: carry-using forms with both carry and both zero inputs
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++) begin
          run(1, x, y, c, (x ^ y ^ c) & 1, 0, 0);
          run(3, x, y, c, (x + y) & 1, 0, 0);
          run(5, x, y, c, ((x + y) >> 1) & 1, 0, 0);
        end
    // R3: equal operands with zero_i low and high
    run(5, 'h40, 'h40, 0, 0, 0, 0);
    run(5, 'h40, 'h40, 0, 1, 0, 0);
    // R5..R11: unary ops over every operand and carry value
    for (int o = 9; o <= 18; o++)
      for (int x = 0; x < 256; x++)
        for (int c = 0; c < 2; c++)
          run(o, x, 255 - x, c, c, 0, 0);
    // R13: word path over many values including the boundaries
    for (int wi = 0; wi < 261; wi++) begin
      int wv;
      case (wi)
        256: wv = 0;
        257: wv = 1;
        258: wv = 'h7FFF;
        259: wv = 'h8000;
        260: wv = 'hFFFF;
        default: wv = (wi * 257) ^ (wi << 3);
      endcase
      wv = wv & 65535;
      for (int iv = 0; iv < 64; iv++) begin
        run(19, wi & 255, 0, iv & 1, 0, wv, iv);
        run(20, wi & 255, 0, iv & 1, 0, wv, iv);
      end
    end
    // R14: every unused code
    for (int o = 21; o < 32; o++)
      for (int x = 0; x < 256; x += 51)
        run(o, x, x ^ 'hFF, 1, 1, 'hABCD, 5);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule